// File: doc/BRIEF.md
# Multi-Width Serial Flash Stream Reader

This block is a master that fetches a run of consecutive bytes from a serial NOR flash, much like the power-on image fetch of a programmable device. A one-cycle `start` pulse latches a 24-bit start address, a byte count and a lane-width code. The controller pulls chip select low and shifts out an 8-bit read opcode and the 24-bit address on lane 0, one bit per serial clock. For dual or quad width it then gives eight dummy clocks. After that it samples one, two or four input lanes on each rising serial clock edge.

Assembled bytes leave on a valid/ready stream. When the consumer stalls, the serial clock stops with its level low, so the flash holds its current output and no byte is lost. After the last byte the clock returns low, chip select goes high, and `done` pulses once the final byte has been accepted.

The sequencer has six states. `S_IDLE` waits for `start`. It goes to `S_SHIFT` (start with a non-zero count) or to `S_FIN` (start with a zero count). `S_SHIFT` makes every serial clock edge. It goes to `S_TAIL` on the falling edge that follows the last data rising edge. `S_TAIL` holds the clock low for a half period and then raises chip select, going to `S_GAP`. `S_GAP` keeps chip select high for a half period and goes to `S_DRAIN`. `S_DRAIN` waits until no byte is pending and goes to `S_FIN`. `S_FIN` drives `done` for one cycle and returns to `S_IDLE`.

Top module: `flash_reader`

## Requirements
- R1: After reset, `cs_n`=1, `sck`=0, `io0_oe`=0, `rd_valid`=0 and `done`=0.
- R2: Each transfer starts with `cs_n` falling. Then 32 bits go out on `io0_out`, most significant bit first: the opcode (0x03 for single, 0x3B for dual, 0x6B for quad), then the 24-bit start address. Each bit is stable across the rising `sck` edge that captures it, and `io0_oe` is 1 for these 32 bits.
- R3: Dual and quad transfers insert exactly 8 dummy `sck` rising edges between the address and the first data edge. Single transfers insert none.
- R4: Width code `width_sel`: 0 = single, 1 = dual, 2 = quad, 3 = single. Single samples `din[1]`. Dual samples `din[1:0]` with `din[1]` more significant. Quad samples `din[3:0]` with `din[3]` most significant. Bytes are assembled MSB first.
- R5: `sck` is low whenever `cs_n` is high. `sck` holds each level for at least CLK_DIV/2 clock cycles.
- R6: While `rd_valid`=1 and `rd_ready`=0, the next cycle still has `rd_valid`=1 with unchanged `rd_data`.
- R7: A stalled stream pauses `sck` and drops no byte. A transfer makes exactly 32 + dummy + N·(8/lanes) rising `sck` edges, whatever the stall pattern.
- R8: Exactly `byte_count` bytes are delivered. The byte at index k comes from address start+k.
- R9: `done` is a single-cycle pulse, given only with `cs_n`=1 and `rd_valid`=0, after the last byte was accepted.
- R10: While a transfer is running, `start`, `start_addr`, `byte_count` and `width_sel` are ignored. There is no second chip-select cycle and the transfer is unchanged.
- R11: `io0_oe` is 0 whenever `cs_n` is high, and 0 from the end of the address through the dummy and data phases.
- R12: A start with `byte_count`=0 pulses `done` with no `cs_n` activity and no serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a transfer |
| start_addr | input | 24 | First flash byte address |
| byte_count | input | CNT_W | Number of bytes to read |
| width_sel | input | 2 | Lane width code (0 single, 1 dual, 2 quad, 3 single) |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock, idles low |
| io0_out | output | 1 | Command/address bit toward lane 0 |
| io0_oe | output | 1 | Drive enable for lane 0 |
| din | input | 4 | Read data lanes 3..0 from the flash |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Consumer accepts the byte |
| done | output | 1 | Transfer-complete pulse |

## Verification
The assertions check on every cycle that the serial clock rests low outside chip select and never toggles faster than its half period. They also check that lane 0 is never driven while deselected, that a stalled byte holds steady, and that `done` appears only with the bus released and the stream empty. Behaviour that depends on whole transfers can only be shown by the bench scenarios, run against a behavioural flash that decodes the opcode and address it receives. These scenarios cover opcode and address order, dummy-clock count, lane bit ordering in each width, the exact number of serial clocks under stall patterns, ignored mid-transfer requests and the zero-length case.

// File: rtl/flash_reader_pkg.sv
package flash_reader_pkg;

    localparam int OP_W       = 8;
    localparam int ADDR_W     = 24;
    localparam int DUMMY_CLKS = 8;

    typedef enum logic [1:0] {
        LW_SINGLE = 2'd0,
        LW_DUAL   = 2'd1,
        LW_QUAD   = 2'd2
    } lane_w_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SHIFT,
        S_TAIL,
        S_GAP,
        S_DRAIN,
        S_FIN
    } rd_state_t;

    function automatic lane_w_t decode_width(input logic [1:0] code);
        case (code)
            2'd1:    return LW_DUAL;
            2'd2:    return LW_QUAD;
            default: return LW_SINGLE;
        endcase
    endfunction

    function automatic logic [OP_W-1:0] opcode_for(input lane_w_t w);
        case (w)
            LW_DUAL: return 8'h3B;
            LW_QUAD: return 8'h6B;
            default: return 8'h03;
        endcase
    endfunction

endpackage

// File: rtl/flash_reader_pacer.sv
module flash_reader_pacer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hold,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;
    logic          at_end;

    assign at_end = (cnt == LAST);
    assign tick   = run && !hold && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (at_end) begin
            if (!hold) cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/flash_reader_lanes.sv
module flash_reader_lanes
    import flash_reader_pkg::*;
(
    input  lane_w_t    width,
    input  logic [7:0] cur,
    input  logic [3:0] din,
    output logic [7:0] nxt,
    output logic [2:0] last_grp
);
    always_comb begin
        unique case (width)
            LW_DUAL: begin
                nxt      = {cur[5:0], din[1:0]};
                last_grp = 3'd3;
            end
            LW_QUAD: begin
                nxt      = {cur[3:0], din[3:0]};
                last_grp = 3'd1;
            end
            default: begin
                nxt      = {cur[6:0], din[1]};
                last_grp = 3'd7;
            end
        endcase
    end
endmodule

// File: rtl/flash_reader_hold.sv
module flash_reader_hold (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    output logic       pend_full,
    output logic       empty,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    input  logic       rd_ready
);
    logic [7:0] pend_byte;

    assign empty = !pend_full && !rd_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_full <= 1'b0;
            pend_byte <= '0;
            rd_data   <= '0;
            rd_valid  <= 1'b0;
        end else begin
            if (pend_full && (!rd_valid || rd_ready)) begin
                rd_data   <= pend_byte;
                rd_valid  <= 1'b1;
                pend_full <= 1'b0;
            end else if (rd_valid && rd_ready) begin
                rd_valid <= 1'b0;
            end
            if (load) begin
                pend_full <= 1'b1;
                pend_byte <= load_byte;
            end
        end
    end
endmodule

// File: rtl/flash_reader.sv
module flash_reader
    import flash_reader_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [23:0]      start_addr,
    input  logic [CNT_W-1:0] byte_count,
    input  logic [1:0]       width_sel,
    output logic             cs_n,
    output logic             sck,
    output logic             io0_out,
    output logic             io0_oe,
    input  logic [3:0]       din,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic             done
);
    localparam int HALF     = (CLK_DIV / 2 < 1) ? 1 : CLK_DIV / 2;
    localparam int HDR_BITS = OP_W + ADDR_W;
    localparam int HC_W     = $clog2(HDR_BITS + DUMMY_CLKS + 1);
    localparam logic [HC_W-1:0] HDR_END  = HC_W'(HDR_BITS);
    localparam logic [HC_W-1:0] HDR_DUMY = HC_W'(HDR_BITS + DUMMY_CLKS);

    rd_state_t state, state_nx;

    lane_w_t              width_q, width_in;
    logic [OP_W-1:0]      op_in;
    logic [HDR_BITS-1:0]  cmd_sr;
    logic [HC_W-1:0]      hdr_cnt, hdr_len;
    logic [2:0]           grp_cnt, last_grp;
    logic [CNT_W-1:0]     bytes_left;
    logic [7:0]           asm_sr, lane_nxt;
    logic                 cs_q, sck_q, io0_q, oe_q;
    logic                 tick, run, hold, pend_full, buf_empty;
    logic                 in_hdr, rise_ev, fall_ev, load;

    assign width_in = decode_width(width_sel);
    assign op_in    = opcode_for(width_in);

    assign in_hdr  = (hdr_cnt < hdr_len);
    assign rise_ev = (state == S_SHIFT) && tick && !sck_q;
    assign fall_ev = (state == S_SHIFT) && tick && sck_q;
    assign load    = rise_ev && !in_hdr && (grp_cnt == last_grp);

    assign run  = (state == S_SHIFT) || (state == S_TAIL) || (state == S_GAP);
    assign hold = (state == S_SHIFT) && pend_full && !sck_q;

    flash_reader_pacer #(.HALF(HALF)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .hold  (hold),
        .tick  (tick)
    );

    flash_reader_lanes u_lanes (
        .width    (width_q),
        .cur      (asm_sr),
        .din      (din),
        .nxt      (lane_nxt),
        .last_grp (last_grp)
    );

    flash_reader_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_byte (lane_nxt),
        .pend_full (pend_full),
        .empty     (buf_empty),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .rd_ready  (rd_ready)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = (byte_count == '0) ? S_FIN : S_SHIFT;
            S_SHIFT: if (fall_ev && !in_hdr && bytes_left == '0) state_nx = S_TAIL;
            S_TAIL:  if (tick) state_nx = S_GAP;
            S_GAP:   if (tick) state_nx = S_DRAIN;
            S_DRAIN: if (buf_empty) state_nx = S_FIN;
            S_FIN:   state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q       <= 1'b1;
            sck_q      <= 1'b0;
            io0_q      <= 1'b0;
            oe_q       <= 1'b0;
            width_q    <= LW_SINGLE;
            cmd_sr     <= '0;
            hdr_cnt    <= '0;
            hdr_len    <= HDR_END;
            grp_cnt    <= '0;
            bytes_left <= '0;
            asm_sr     <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start && byte_count != '0) begin
                        cs_q       <= 1'b0;
                        oe_q       <= 1'b1;
                        io0_q      <= op_in[OP_W-1];
                        cmd_sr     <= {op_in, start_addr};
                        width_q    <= width_in;
                        hdr_len    <= (width_in == LW_SINGLE) ? HDR_END : HDR_DUMY;
                        hdr_cnt    <= '0;
                        grp_cnt    <= '0;
                        bytes_left <= byte_count;
                    end
                end
                S_SHIFT: begin
                    if (rise_ev) begin
                        sck_q <= 1'b1;
                        if (in_hdr) begin
                            hdr_cnt <= hdr_cnt + 1'b1;
                        end else begin
                            asm_sr <= lane_nxt;
                            if (grp_cnt == last_grp) begin
                                grp_cnt    <= '0;
                                bytes_left <= bytes_left - 1'b1;
                            end else begin
                                grp_cnt <= grp_cnt + 1'b1;
                            end
                        end
                    end else if (fall_ev) begin
                        sck_q <= 1'b0;
                        if (hdr_cnt < HDR_END) begin
                            io0_q  <= cmd_sr[HDR_BITS-2];
                            cmd_sr <= {cmd_sr[HDR_BITS-2:0], 1'b0};
                        end else begin
                            io0_q <= 1'b0;
                            oe_q  <= 1'b0;
                        end
                    end
                end
                S_TAIL: begin
                    if (tick) cs_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign cs_n    = cs_q;
    assign sck     = sck_q;
    assign io0_out = io0_q;
    assign io0_oe  = oe_q;
    assign done    = (state == S_FIN);

endmodule

// File: rtl/flash_reader_chk.sv
module flash_reader_chk #(
    parameter int HALF = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sck,
    input logic       io0_oe,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [7:0] rd_data,
    input logic       done
);
    localparam int SPAN = (HALF - 1 > 200) ? 200 : HALF - 1;

    logic       sck_d;
    logic [7:0] since;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            since <= '0;
        end else begin
            sck_d <= sck;
            if (sck != sck_d)    since <= '0;
            else if (since != 8'hFF) since <= since + 1'b1;
        end
    end

    // R5: clock rests low while deselected
    a_r5_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    // R5: each clock level lasts at least a half period
    a_r5_sck_half: assert property (@(posedge clk) disable iff (!rst_n)
        (sck != sck_d) |-> (32'(since) >= SPAN));

    // R6: stalled byte is held
    a_r6_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R9: completion only with bus released and stream empty
    a_r9_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !rd_valid));

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: lane 0 not driven while deselected
    a_r11_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !io0_oe);
endmodule

bind flash_reader flash_reader_chk #(.HALF(HALF)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sck      (sck),
    .io0_oe   (io0_oe),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .done     (done)
);

// File: tb/sim_flash_reader.sv
module sim_flash_reader;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [23:0]      start_addr = '0;
    logic [CNT_W-1:0] byte_count = '0;
    logic [1:0]       width_sel = '0;
    logic             cs_n, sck, io0_out, io0_oe;
    logic [3:0]       din = '0;
    logic [7:0]       rd_data;
    logic             rd_valid;
    logic             rd_ready = 1'b0;
    logic             done;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    flash_reader #(.CLK_DIV(4), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .width_sel(width_sel), .cs_n(cs_n), .sck(sck),
        .io0_out(io0_out), .io0_oe(io0_oe), .din(din), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .done(done)
    );

    // behavioural flash
    int          rises = 0;
    int          oe_err = 0;
    int          cs_falls = 0;
    int          m_lanes = 1;
    int          m_dum = 0;
    logic [31:0] hdr = '0;
    logic [23:0] cap_addr = '0;

    function automatic logic [7:0] pat(input logic [23:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    always @(negedge cs_n) begin
        rises = 0;
        cs_falls++;
    end

    always @(posedge sck) begin
        if (!cs_n) begin
            if (rises < 32) begin
                hdr = {hdr[30:0], io0_out};
                if (!io0_oe) oe_err++;
            end else if (io0_oe) begin
                oe_err++;
            end
            rises++;
            if (rises == 32) begin
                cap_addr = hdr[23:0];
                case (hdr[31:24])
                    8'h3B:   begin m_lanes = 2; m_dum = 8; end
                    8'h6B:   begin m_lanes = 4; m_dum = 8; end
                    default: begin m_lanes = 1; m_dum = 0; end
                endcase
            end
        end
    end

    always @(negedge sck) begin
        if (!cs_n && rises >= 32 + m_dum) begin
            int k, gpb;
            logic [7:0] b, sh;
            k   = rises - 32 - m_dum;
            gpb = 8 / m_lanes;
            b   = pat(cap_addr + 24'(k / gpb));
            sh  = b >> (8 - m_lanes * (k % gpb + 1));
            case (m_lanes)
                1:       din <= {2'b00, sh[0], 1'b0};
                2:       din <= {2'b00, sh[1:0]};
                default: din <= sh[3:0];
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one transfer: rdy_div 1 = always ready, else ready every rdy_div cycles
    task automatic run_xfer(input logic [1:0] wcode, input logic [23:0] addr,
                            input int n, input int rdy_div, input bit poke,
                            input string tag);
        int lanes, dum, got_n, cyc, bad_idx, falls0;
        bit seen_done;
        logic [7:0] got [0:63];
        lanes = (wcode == 2'd1) ? 2 : (wcode == 2'd2) ? 4 : 1;
        dum   = (lanes == 1) ? 0 : 8;
        falls0 = cs_falls;
        oe_err = 0;
        @(negedge clk);
        width_sel = wcode; start_addr = addr; byte_count = CNT_W'(n); start = 1'b1;
        got_n = 0; cyc = 0; seen_done = 0; bad_idx = -1;
        while (!seen_done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            rd_ready = (rdy_div <= 1) ? 1'b1 : (cyc % rdy_div == 0);
            if (poke && cyc == 30) begin
                start = 1'b1; start_addr = ~addr; byte_count = 16'd3;
                width_sel = wcode ^ 2'b11;
            end else begin
                start = 1'b0;
            end
            #1;
            if (rd_valid && rd_ready) begin
                if (got_n < 64) got[got_n] = rd_data;
                got_n++;
            end
            if (done) begin
                seen_done = 1;
                chk(cs_n == 1'b1, "R9", {tag, " cs_n at done"}, cs_n, 1);
                chk(rd_valid == 1'b0, "R9", {tag, " rd_valid at done"}, rd_valid, 0);
            end
        end
        start = 1'b0;
        rd_ready = 1'b0;
        chk(seen_done, "R9", {tag, " done seen"}, seen_done, 1);
        chk(got_n == n, "R8", {tag, " byte count"}, got_n, n);
        for (int i = 0; i < n && i < 64 && i < got_n; i++)
            if (bad_idx < 0 && got[i] != pat(addr + 24'(i))) bad_idx = i;
        chk(bad_idx < 0, "R4", {tag, " byte values (R3 dummy alignment)"},
            (bad_idx < 0) ? 0 : got[bad_idx],
            (bad_idx < 0) ? 0 : pat(addr + 24'(bad_idx)));
        chk(hdr[31:24] == ((lanes == 1) ? 8'h03 : (lanes == 2) ? 8'h3B : 8'h6B),
            "R2", {tag, " opcode"}, hdr[31:24],
            (lanes == 1) ? 8'h03 : (lanes == 2) ? 8'h3B : 8'h6B);
        chk(cap_addr == addr, "R2", {tag, " address"}, cap_addr, addr);
        chk(oe_err == 0, "R11", {tag, " lane0 drive phases"}, oe_err, 0);
        chk(rises == 32 + dum + n * (8 / lanes), "R7", {tag, " sck rising edges"},
            rises, 32 + dum + n * (8 / lanes));
        chk(cs_falls - falls0 == 1, "R10", {tag, " chip-select cycles"},
            cs_falls - falls0, 1);
        @(negedge clk);
        chk(sck == 1'b0 && cs_n == 1'b1, "R5", {tag, " idle bus"}, {sck, cs_n}, 1);
    endtask

    task automatic t_reset;
        chk(cs_n == 1'b1, "R1", "reset cs_n", cs_n, 1);
        chk(sck == 1'b0, "R1", "reset sck", sck, 0);
        chk(io0_oe == 1'b0, "R1", "reset io0_oe", io0_oe, 0);
        chk(rd_valid == 1'b0, "R1", "reset rd_valid", rd_valid, 0);
        chk(done == 1'b0, "R1", "reset done", done, 0);
    endtask

    task automatic t_zero_count;
        int dn, cs_low, sck_hi;
        dn = 0; cs_low = 0; sck_hi = 0;
        @(negedge clk);
        byte_count = '0; start_addr = 24'h000100; width_sel = 2'd2; start = 1'b1;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (done) dn++;
            if (!cs_n) cs_low++;
            if (sck) sck_hi++;
        end
        chk(dn == 1, "R12", "zero count done pulses", dn, 1);
        chk(cs_low == 0, "R12", "zero count cs_n activity", cs_low, 0);
        chk(sck_hi == 0, "R12", "zero count sck activity", sck_hi, 0);
    endtask

    initial begin
        #(4 * 190000);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_xfer(2'd0, 24'h012345, 6, 1, 1'b0, "single");
        run_xfer(2'd1, 24'h00FFFE, 5, 1, 1'b0, "dual");
        run_xfer(2'd2, 24'hABCDEF, 12, 1, 1'b0, "quad");
        run_xfer(2'd3, 24'h000010, 4, 1, 1'b0, "code3 single");
        run_xfer(2'd2, 24'h3F0000, 10, 13, 1'b0, "quad stalled");
        run_xfer(2'd1, 24'h7654AA, 7, 9, 1'b0, "dual stalled");
        run_xfer(2'd0, 24'hFFFFFD, 3, 17, 1'b0, "single stalled");
        run_xfer(2'd2, 24'h102030, 20, 1, 1'b1, "quad busy start");
        t_zero_count();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule